// File: doc/BRIEF.md
# Selectable Clock Divider With Phase Slip

This block takes a fast sample clock and produces a divided clock at a ratio of 1, 2 or 4. The ratio comes from a 3-bit select field that software writes over a register strobe interface. A zero code, and any code not listed below, hands the choice to a 2-bit pin input. Register writes arrive on a slower register clock. The select field and the slip request are carried into the fast clock domain through synchronizers.

When several converters share one input clock, the phase of each divided clock is unknown after start-up. Software lines them up by issuing slip commands. A command is a rising transition of bit 0 at the slip address, that is, a write of 1 while the stored bit is 0. Each command moves the divided clock's edge schedule by one input cycle. A 2-bit phase counter is exposed on the ports so that the current position can be observed.

A soft reset input clears the stored slip bit. It leaves the divider select field untouched.

Top module: `clk_div_slip`

## Requirements
- R1: While rst_ni is low, phase_o is 0. Reset leaves the select field at 000, so the ratio comes from the pin input.
- R2: A write to address 0x72 stores wr_data_i[2:0] as the select code: 001 selects divide-by-1, 010 selects divide-by-2 and 100 selects divide-by-4. In each case the pin input is overridden.
- R3: With select code 000, or any code other than 001, 010 and 100, the pin input picks the ratio: pin 00 gives 1, pin 01 gives 2, and pin 10 or 11 gives 4.
- R4: In divide-by-4, phase_o counts 0,1,2,3 and div_clk_o is high in phases 0 and 1. In divide-by-2, phase_o alternates 0,1 and div_clk_o is high in phase 0.
- R5: In divide-by-1, phase_o stays 0 and div_clk_o follows the input clock.
- R6: A write to address 0x71 stores wr_data_i[0]. A slip command is issued only when a 1 is written while the stored bit is 0. Writing 1 over a stored 1, or writing 0, issues no command.
- R7: In divide-by-4, each command advances the phase by one input cycle. The counter steps from 1 to 3, so (phase_o − input cycle count) mod 4 grows by 1.
- R8: In divide-by-2, each command holds phase 0 for one extra input cycle. This shifts (phase_o − input cycle count) mod 2 by 1.
- R9: In divide-by-1, a command has no effect: phase_o stays 0 and the period stays one input cycle.
- R10: soft_rst_i clears the stored slip bit, so a following write of 1 issues a command. The select field keeps its value.
- R11: When the effective ratio changes, phase_o restarts at 0 in the next cycle, and a slip due in that cycle is kept pending.
- R12: Commands issued faster than they can be applied are counted as pending. Each one takes effect exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| reg_clk_i | input | 1 | Register interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| soft_rst_i | input | 1 | Soft reset, register clock domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| pin_div_sel_i | input | 2 | Pin ratio choice used when the select field defers to it |
| div_clk_o | output | 1 | Divided clock |
| phase_o | output | 2 | Current divider phase count |

## Verification
Two functions can land in the same fast cycle in this block. One is the arrival of a new slip pulse from the synchronizer. The other is the application of an earlier pending slip, so the pending count is incremented and decremented at once. The bench provokes this by writing 1, 0, 1 to the slip bit on consecutive register cycles in divide-by-4. It judges the result by measuring the phase offset against a free-running input cycle count, which must have moved by exactly two. A ratio change that coincides with a due slip is checked by an assertion: the counter must restart at 0.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned PH_W = 2;
  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic [1:0] {
    RAT_1 = 2'd0,
    RAT_2 = 2'd1,
    RAT_4 = 2'd2
  } ratio_e;

  localparam logic [2:0] CODE_DIV1 = 3'b001;
  localparam logic [2:0] CODE_DIV2 = 3'b010;
  localparam logic [2:0] CODE_DIV4 = 3'b100;
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       SEL_W     = 3,
  parameter logic [ADDR_W-1:0] SEL_ADDR  = 8'h72,
  parameter logic [ADDR_W-1:0] SLIP_ADDR = 8'h71
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              slip_tgl_o
);
  logic [SEL_W-1:0] sel_q;
  logic             slip_q, tgl_q;
  logic             sel_wr, slip_wr;
  logic             unused_data;

  assign sel_wr      = wr_en_i && (wr_addr_i == SEL_ADDR);
  assign slip_wr     = wr_en_i && (wr_addr_i == SLIP_ADDR);
  assign unused_data = ^wr_data_i[DATA_W-1:SEL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      slip_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= wr_data_i[SEL_W-1:0];
      if (soft_rst_i) begin
        slip_q <= 1'b0;
      end else if (slip_wr) begin
        slip_q <= wr_data_i[0];
        // command only on a 0 -> 1 transition of the stored bit
        if (wr_data_i[0] && !slip_q) tgl_q <= ~tgl_q;
      end
    end
  end

  assign sel_o      = sel_q;
  assign slip_tgl_o = tgl_q;

  // R6
  slip_rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgl_q) |-> $past(slip_wr && wr_data_i[0] && !slip_q && !soft_rst_i));

  // R10
  soft_keeps_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !sel_wr) |=> $stable(sel_q));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int unsigned PEND_W = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_e ratio_i,
  input  logic   slip_i,
  output logic   div_o,
  output phase_t phase_o,
  output ratio_e ratio_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  ratio_e            ratio_q, ratio_nxt;
  phase_t            cnt_q, cnt_d, mask, slip_pt, step;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              div_q, div_d, chg, apply;

  function automatic logic level(ratio_e r, phase_t p);
    case (r)
      RAT_4:   return !p[1];
      RAT_2:   return !p[0];
      default: return 1'b1;
    endcase
  endfunction

  always_comb begin
    case (ratio_q)
      RAT_4:   begin mask = 2'd3; slip_pt = 2'd1; end
      RAT_2:   begin mask = 2'd1; slip_pt = 2'd0; end
      default: begin mask = 2'd0; slip_pt = 2'd0; end
    endcase
  end

  assign chg       = (ratio_i != ratio_q);
  assign ratio_nxt = chg ? ratio_i : ratio_q;
  // slip applied at the last high phase; held back while the ratio changes
  assign apply     = (pend_q != '0) && !chg && (cnt_q == slip_pt);
  assign step      = apply ? 2'd2 : 2'd1;
  assign cnt_d     = chg ? '0 : ((cnt_q + step) & mask);
  assign div_d     = level(ratio_nxt, cnt_d);

  always_comb begin
    pend_d = pend_q;
    if (slip_i && !apply) begin
      if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
    end else if (!slip_i && apply) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RAT_1;
      cnt_q   <= '0;
      div_q   <= 1'b1;
      pend_q  <= '0;
    end else begin
      ratio_q <= ratio_nxt;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      pend_q  <= pend_d;
    end
  end

  assign div_o   = div_q;
  assign phase_o = cnt_q;
  assign ratio_o = ratio_q;

  // R11
  ratio_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i != ratio_q) |=> (cnt_q == '0));

  // R5
  div1_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q == RAT_1) |-> (cnt_q == '0));

  // R4
  div4_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q == RAT_4) |-> (div_q == !cnt_q[1]));

  // R7
  div4_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q == RAT_4 && ratio_i == RAT_4) |=>
      (cnt_q == phase_t'($past(cnt_q) + 2'd1) || cnt_q == phase_t'($past(cnt_q) + 2'd2)));
endmodule

// File: rtl/clk_div_slip.sv
module clk_div_slip
  import clkdiv_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 8'h72,
  parameter logic [ADDR_W-1:0] SLIP_ADDR   = 8'h71,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       PEND_W      = 2
) (
  input  logic              clk_i,
  input  logic              reg_clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        pin_div_sel_i,
  output logic              div_clk_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CFG_W = SEL_W + 2;

  logic [SEL_W-1:0] sel;
  logic [CFG_W-1:0] cfg_s, cfg_prev_q, cfg_q;
  logic             tgl, tgl_s, tgl_d_q, slip_pulse, div_q;
  ratio_e           ratio_sel, ratio_cur;

  clkdiv_cfg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .SEL_ADDR(SEL_ADDR), .SLIP_ADDR(SLIP_ADDR)
  ) u_cfg (
    .clk_i(reg_clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .sel_o(sel), .slip_tgl_o(tgl)
  );

  clkdiv_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({pin_div_sel_i, sel}), .q_o(cfg_s)
  );

  clkdiv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_slip_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tgl), .q_o(tgl_s)
  );

  // accept a multi-bit config only after two equal synchronized samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_prev_q <= '0;
      cfg_q      <= '0;
      tgl_d_q    <= 1'b0;
    end else begin
      cfg_prev_q <= cfg_s;
      if (cfg_s == cfg_prev_q) cfg_q <= cfg_s;
      tgl_d_q    <= tgl_s;
    end
  end

  assign slip_pulse = tgl_s ^ tgl_d_q;

  always_comb begin
    unique case (cfg_q[SEL_W-1:0])
      CODE_DIV1: ratio_sel = RAT_1;
      CODE_DIV2: ratio_sel = RAT_2;
      CODE_DIV4: ratio_sel = RAT_4;
      default: begin
        if (cfg_q[SEL_W+1])    ratio_sel = RAT_4;
        else if (cfg_q[SEL_W]) ratio_sel = RAT_2;
        else                   ratio_sel = RAT_1;
      end
    endcase
  end

  clkdiv_core #(.PEND_W(PEND_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_sel), .slip_i(slip_pulse),
    .div_o(div_q), .phase_o(phase_o), .ratio_o(ratio_cur)
  );

  assign div_clk_o = (ratio_cur == RAT_1) ? clk_i : div_q;
endmodule

// File: tb/test_clk_div_slip.sv
module test_clk_div_slip;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 26;
  localparam int K_RATIO = 0, K_BASE = 1, K_SHIFT = 2, K_SHAPE = 3, K_DIV1 = 4;

  typedef struct packed {
    int kind;
    int mod_n;
    int exp;
  } item_t;

  logic       clk_i = 1'b0, reg_clk_i = 1'b0, rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0, wr_data_i = '0;
  logic [1:0] pin_div_sel_i = 2'b00;
  logic       div_clk_o;
  logic [1:0] phase_o;

  int    checks = 0, fails = 0, ref_cnt = 0, base = 0;
  item_t sb_q[$];
  string tag_q[$];

  clk_div_slip i_clk_div_slip (
    .clk_i(clk_i), .reg_clk_i(reg_clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pin_div_sel_i(pin_div_sel_i), .div_clk_o(div_clk_o), .phase_o(phase_o)
  );

  always #(CLK_PERIOD/2)  clk_i     = ~clk_i;
  always #(RCLK_PERIOD/2) reg_clk_i = ~reg_clk_i;
  always @(posedge clk_i) ref_cnt <= ref_cnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic push(input string tag, input int kind, input int m, input int exp);
    item_t it;
    it.kind = kind; it.mod_n = m; it.exp = exp;
    sb_q.push_back(it);
    tag_q.push_back(tag);
    wait (sb_q.size() == 0);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge reg_clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge reg_clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk_i);
  endtask

  function automatic int offset(input int m);
    int d;
    d = (int'(phase_o) - (ref_cnt % m)) % m;
    return (d + m) % m;
  endfunction

  task automatic run_item(input item_t it, input string tag);
    int n, g, o, p_prev;
    bit ok, hi, lo;
    case (it.kind)
      K_RATIO: begin
        g = 0;
        while (phase_o != 2'd0 && g < 16) begin @(negedge clk_i); g++; end
        n = 0;
        do begin @(negedge clk_i); n++; end while (phase_o != 2'd0 && n < 16);
        check(n == it.exp, tag, n, it.exp);
      end
      K_BASE: base = offset(it.mod_n);
      K_SHIFT: begin
        o = offset(it.mod_n);
        check(o == (base + it.exp) % it.mod_n, tag, o, (base + it.exp) % it.mod_n);
      end
      K_SHAPE: begin
        ok = 1'b1;
        p_prev = int'(phase_o);
        for (int i = 0; i < 8; i++) begin
          @(negedge clk_i);
          if (int'(phase_o) != (p_prev + 1) % it.mod_n) ok = 1'b0;
          if (it.mod_n == 4 && div_clk_o != (phase_o < 2'd2)) ok = 1'b0;
          if (it.mod_n == 2 && div_clk_o != (phase_o == 2'd0)) ok = 1'b0;
          p_prev = int'(phase_o);
        end
        check(ok, tag, int'(ok), 1);
      end
      default: begin
        @(posedge clk_i); #(CLK_PERIOD/4); hi = div_clk_o;
        @(negedge clk_i); #(CLK_PERIOD/4); lo = div_clk_o;
        check(hi && !lo && phase_o == 2'd0, tag, {hi, lo}, 2);
      end
    endcase
  endtask

  // monitor: pops scoreboard items and judges them against the outputs
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      if (sb_q.size() != 0) begin
        it = sb_q[0];
        run_item(it, tag_q[0]);
        void'(tag_q.pop_front());
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(phase_o == 2'd0, "R1 reset phase", int'(phase_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    settle();
    push("R3 pin00 div1", K_RATIO, 1, 1);
    push("R5 div1 follows clock", K_DIV1, 1, 0);
    pin_div_sel_i = 2'b01; settle();
    push("R1 R3 pin01 div2", K_RATIO, 2, 2);
    pin_div_sel_i = 2'b10; settle();
    push("R3 pin10 div4", K_RATIO, 4, 4);
    push("R4 div4 shape", K_SHAPE, 4, 0);
    reg_write(8'h72, 8'b1111_1010); settle();
    push("R2 code010 div2", K_RATIO, 2, 2);
    push("R4 div2 shape", K_SHAPE, 2, 0);
    pin_div_sel_i = 2'b00;
    reg_write(8'h72, 8'h04); settle();
    push("R2 code100 div4", K_RATIO, 4, 4);
    // R6 R7 single command
    push("R7 base", K_BASE, 4, 0);
    reg_write(8'h71, 8'h00); reg_write(8'h71, 8'h01); settle();
    push("R7 one slip", K_SHIFT, 4, 1);
    push("R6 base", K_BASE, 4, 0);
    reg_write(8'h71, 8'h01); settle();
    push("R6 repeated one no slip", K_SHIFT, 4, 0);
    push("R6 base", K_BASE, 4, 0);
    reg_write(8'h71, 8'h00); settle();
    push("R6 zero no slip", K_SHIFT, 4, 0);
    // R12 two commands back to back
    push("R12 base", K_BASE, 4, 0);
    reg_write(8'h71, 8'h01); reg_write(8'h71, 8'h00); reg_write(8'h71, 8'h01); settle();
    push("R12 R7 two slips", K_SHIFT, 4, 2);
    push("R4 shape after slips", K_SHAPE, 4, 0);
    pin_div_sel_i = 2'b01;
    reg_write(8'h72, 8'h03); settle();
    push("R3 invalid code to pin", K_RATIO, 2, 2);
    reg_write(8'h72, 8'h04); settle();
    reg_write(8'h72, 8'h02); settle();
    push("R11 ratio change resync", K_SHAPE, 2, 0);
    // R8
    push("R8 base", K_BASE, 2, 0);
    reg_write(8'h71, 8'h00); reg_write(8'h71, 8'h01); settle();
    push("R8 div2 slip", K_SHIFT, 2, 1);
    // R9
    reg_write(8'h72, 8'h01); settle();
    push("R2 code001 div1", K_RATIO, 1, 1);
    reg_write(8'h71, 8'h00); reg_write(8'h71, 8'h01); settle();
    push("R9 div1 slip no effect", K_RATIO, 1, 1);
    push("R9 div1 clock after slip", K_DIV1, 1, 0);
    // R10
    reg_write(8'h72, 8'h02); pin_div_sel_i = 2'b10; settle();
    @(negedge reg_clk_i); soft_rst_i = 1'b1;
    @(negedge reg_clk_i); soft_rst_i = 1'b0;
    settle();
    push("R10 select kept", K_RATIO, 2, 2);
    push("R10 base", K_BASE, 2, 0);
    reg_write(8'h71, 8'h01); settle();
    push("R10 slip after soft reset", K_SHIFT, 2, 1);
    report();
    $finish;
  end
endmodule